// File: doc/BRIEF.md
# Sound Generator Register-Select Front End

This block sits between a byte-wide processor bus and the register file of a three-channel programmable sound generator. The bus sees a small window where the low two address bits pick a lane. Lane 0 written holds an 8-bit select value. Lane 2 written stores a data byte into the register that the select value names. Reading lane 0 returns the selected register. The window repeats every four bytes.

The block holds sixteen 8-bit registers and exposes their contents to the tone and envelope engine as one flat vector. Some register writes carry side effects for that engine, and the block reports each of them as a one-cycle strobe:
- writing register 12 clears the envelope position;
- writing register 13 restarts the envelope;
- writing registers 8, 9 and 10 tells channel A, B or C that its amplitude changed.

Each access gets a registered response one cycle later. The response carries the read byte and the number of wait cycles the bus must insert.

Top module: `snd_regsel_if`

## Requirements
- R1: After reset every register, the select value, the response outputs and all strobes are 0, except that `rsp_rdata` is 0xFF.
- R2: A write whose address has bits [1:0] = 0 stores the whole 8-bit data byte as the select value.
- R3: A write whose address has bits [1:0] = 2 stores the data byte into register `sel` only when `sel` < 16. Otherwise no register changes.
- R4: A read whose address has bits [1:0] = 0 returns register `sel` when `sel` < 16, and 0xFF when `sel` >= 16.
- R5: A read whose address has bits [1:0] equal to 1, 2 or 3 returns 0xFF.
- R6: A write whose address has bits [1:0] equal to 1 or 3 changes neither the select value nor any register.
- R7: A write that takes effect on register 12 pulses `env_pos_clr` high for exactly one cycle, in the response cycle.
- R8: A write that takes effect on register 13 pulses `env_restart` high for exactly one cycle, in the response cycle.
- R9: A write that takes effect on register 8, 9 or 10 pulses `amp_upd` bit 0, 1 or 2 respectively for one cycle, in the response cycle. At most one bit is ever high.
- R10: `rsp_wait` is 4 for a read with address bits [1:0] = 0, and 1 for any other read. For a write it is 1 when the address is below 4 and 0 otherwise.
- R11: Every access cycle produces `rsp_valid` high in exactly the next cycle, with `rsp_rdata` and `rsp_wait` valid there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte offset inside the sound window |
| acc_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | 8 | Read byte (0xFF for writes and open lanes) |
| rsp_wait | output | 3 | Wait cycles to insert for that access |
| env_pos_clr | output | 1 | Envelope position clear strobe |
| env_restart | output | 1 | Envelope restart strobe |
| amp_upd | output | 3 | Per-channel amplitude-update strobes (bit 0 = A) |
| reg_image | output | 128 | All registers, register i at bits [8i+7:8i] |

## Verification
A wrong select value shows up on the very next lane-0 read as the wrong register or as an unexpected 0xFF. It also shows up one cycle after the next lane-2 write, as a missing or misplaced strobe and a changed slice of `reg_image`. A corrupted register is visible in `reg_image` one cycle after the faulty write, so the bench compares the whole image against its model after each group of accesses. A decode fault in the lanes or the window shows as a wrong `rsp_wait` in the response cycle of that same access.

// File: rtl/snd_rs_pkg.sv
package snd_rs_pkg;
  localparam int unsigned REG_AMP_BASE  = 8;
  localparam int unsigned REG_ENV_POS   = 12;
  localparam int unsigned REG_ENV_SHAPE = 13;
  localparam int unsigned NUM_CH        = 3;
  localparam int unsigned WAIT_W        = 3;

  typedef enum logic [1:0] {
    LANE_SEL  = 2'd0,
    LANE_ODD1 = 2'd1,
    LANE_DATA = 2'd2,
    LANE_ODD3 = 2'd3
  } lane_e;

  typedef struct packed {
    logic sel_wr;
    logic reg_wr;
    logic rd_sel;
  } acc_dec_t;

  // Wait cycles charged to one access.
  function automatic logic [WAIT_W-1:0] access_wait(input logic is_rd,
                                                     input lane_e lane,
                                                     input logic low_window);
    logic [WAIT_W-1:0] w;
    if (is_rd) w = (lane == LANE_SEL) ? WAIT_W'(4) : WAIT_W'(1);
    else       w = low_window ? WAIT_W'(1) : WAIT_W'(0);
    return w;
  endfunction
endpackage

// File: rtl/snd_rs_decode.sv
module snd_rs_decode
  import snd_rs_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [AW-1:0]     acc_addr,
  output acc_dec_t          dec,
  output logic [WAIT_W-1:0] wait_n
);
  lane_e lane;
  logic  low_window;

  assign lane       = lane_e'(acc_addr[1:0]);
  assign low_window = (acc_addr[AW-1:2] == '0);

  always_comb begin
    dec.sel_wr = acc_valid &&  acc_write && (lane == LANE_SEL);
    dec.reg_wr = acc_valid &&  acc_write && (lane == LANE_DATA);
    dec.rd_sel = acc_valid && !acc_write && (lane == LANE_SEL);
    wait_n     = acc_valid ? access_wait(!acc_write, lane, low_window) : '0;
  end
endmodule

// File: rtl/snd_rs_bank.sv
module snd_rs_bank #(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 16,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_wr,
  input  logic               reg_wr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      sel_q,
  output logic               sel_ok,
  output logic [IW-1:0]      sel_idx,
  output logic [DW-1:0]      rd_byte,
  output logic [NREG*DW-1:0] image
);
  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_wr) sel_q <= wdata;
  end

  assign sel_ok  = (sel_q < DW'(NREG));
  assign sel_idx = sel_q[IW-1:0];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                   q <= '0;
      else if (reg_wr && sel_ok && sel_idx == IW'(i)) q <= wdata;
    end
    assign image[i*DW +: DW] = q;
  end

  assign rd_byte = sel_ok ? image[sel_idx*DW +: DW] : '1;
endmodule

// File: rtl/snd_rs_strobe.sv
module snd_rs_strobe
  import snd_rs_pkg::*;
#(
  parameter int unsigned IW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [IW-1:0]     idx,
  output logic              env_pos_clr,
  output logic              env_restart,
  output logic [NUM_CH-1:0] amp_upd
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      env_pos_clr <= 1'b0;
      env_restart <= 1'b0;
    end else begin
      env_pos_clr <= hit && (idx == IW'(REG_ENV_POS));
      env_restart <= hit && (idx == IW'(REG_ENV_SHAPE));
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_amp
    always_ff @(posedge clk) begin
      if (!rst_n) amp_upd[c] <= 1'b0;
      else        amp_upd[c] <= hit && (idx == IW'(REG_AMP_BASE + c));
    end
  end
endmodule

// File: rtl/snd_regsel_if.sv
module snd_regsel_if
  import snd_rs_pkg::*;
#(
  parameter int unsigned AW   = 8,
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 16,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [AW-1:0]      acc_addr,
  input  logic [DW-1:0]      acc_wdata,
  output logic               rsp_valid,
  output logic [DW-1:0]      rsp_rdata,
  output logic [WAIT_W-1:0]  rsp_wait,
  output logic               env_pos_clr,
  output logic               env_restart,
  output logic [NUM_CH-1:0]  amp_upd,
  output logic [NREG*DW-1:0] reg_image
);
  acc_dec_t          dec;
  logic [WAIT_W-1:0] wait_n;
  logic [DW-1:0]     sel_q;
  logic              sel_ok;
  logic [IW-1:0]     sel_idx;
  logic [DW-1:0]     rd_byte;
  logic              reg_hit;

  snd_rs_decode #(.AW(AW)) u_dec (
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .dec(dec), .wait_n(wait_n)
  );

  snd_rs_bank #(.DW(DW), .NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n), .sel_wr(dec.sel_wr), .reg_wr(dec.reg_wr),
    .wdata(acc_wdata), .sel_q(sel_q), .sel_ok(sel_ok), .sel_idx(sel_idx),
    .rd_byte(rd_byte), .image(reg_image)
  );

  assign reg_hit = dec.reg_wr && sel_ok;

  snd_rs_strobe #(.IW(IW)) u_stb (
    .clk(clk), .rst_n(rst_n), .hit(reg_hit), .idx(sel_idx),
    .env_pos_clr(env_pos_clr), .env_restart(env_restart), .amp_upd(amp_upd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '1;
      rsp_wait  <= '0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_wait  <= wait_n;
      if (acc_valid) rsp_rdata <= dec.rd_sel ? rd_byte : '1;
    end
  end
endmodule

// File: rtl/snd_rs_chk.sv
module snd_rs_chk #(
  parameter int unsigned AW   = 8,
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic               acc_write,
  input logic [AW-1:0]      acc_addr,
  input logic [DW-1:0]      acc_wdata,
  input logic               rsp_valid,
  input logic [DW-1:0]      rsp_rdata,
  input logic [2:0]         rsp_wait,
  input logic               env_pos_clr,
  input logic               env_restart,
  input logic [2:0]         amp_upd,
  input logic [NREG*DW-1:0] reg_image,
  input logic [DW-1:0]      sel_q
);
  a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);

  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !rsp_valid);

  a_r9_amp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(amp_upd));

  a_r3_ignored_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_addr[1:0] == 2'd2 && sel_q >= DW'(NREG))
    |=> $stable(reg_image));

  a_r5_open_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_addr[1:0] != 2'd0) |=> rsp_rdata == '1);

  a_r2_sel_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_addr[1:0] == 2'd0) |=> sel_q == $past(acc_wdata));

  a_r7_pos_clr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    env_pos_clr |-> rsp_valid);

  a_r8_restart_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    env_restart |-> rsp_valid && !env_pos_clr && amp_upd == 3'b000);

  a_r10_wait_range: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_wait <= 3'd4);
endmodule

bind snd_regsel_if snd_rs_chk #(.AW(AW), .DW(DW), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_wait(rsp_wait), .env_pos_clr(env_pos_clr),
  .env_restart(env_restart), .amp_upd(amp_upd), .reg_image(reg_image),
  .sel_q(sel_q)
);

// File: tb/snd_regsel_if_tb.sv
module snd_regsel_if_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         acc_valid = 1'b0;
  logic         acc_write = 1'b0;
  logic [7:0]   acc_addr = '0;
  logic [7:0]   acc_wdata = '0;
  logic         rsp_valid;
  logic [7:0]   rsp_rdata;
  logic [2:0]   rsp_wait;
  logic         env_pos_clr;
  logic         env_restart;
  logic [2:0]   amp_upd;
  logic [127:0] reg_image;

  always #2.5 clk = ~clk;

  snd_regsel_if u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_wait(rsp_wait), .env_pos_clr(env_pos_clr),
    .env_restart(env_restart), .amp_upd(amp_upd), .reg_image(reg_image)
  );

  typedef struct packed {
    logic [7:0] rdata;
    logic [2:0] wt;
    logic [4:0] stb;   // {pos_clr, restart, amp[2:0]}
    logic [7:0] rq;
  } exp_t;

  exp_t       sb[$];
  int         total = 0;
  int         bad = 0;
  int         pushed = 0;
  int         popped = 0;
  logic [7:0] m_sel = '0;
  logic [7:0] m_reg [16];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: one access per cycle; expected response goes to the scoreboard.
  task automatic acc(input bit w, input logic [7:0] a, input logic [7:0] d,
                     input logic [7:0] rq);
    exp_t e;
    e.rq    = rq;
    e.rdata = (!w && a[1:0] == 2'd0) ? ((m_sel < 16) ? m_reg[m_sel[3:0]] : 8'hFF) : 8'hFF;
    e.wt    = !w ? ((a[1:0] == 2'd0) ? 3'd4 : 3'd1) : ((a < 8'd4) ? 3'd1 : 3'd0);
    e.stb   = '0;
    if (w && a[1:0] == 2'd2 && m_sel < 16) begin
      e.stb[4] = (m_sel == 12);
      e.stb[3] = (m_sel == 13);
      for (int c = 0; c < 3; c++) e.stb[c] = (m_sel == 8 + c);
      m_reg[m_sel[3:0]] = d;
    end
    if (w && a[1:0] == 2'd0) m_sel = d;
    sb.push_back(e);
    pushed++;
    acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_wdata = d;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    acc_valid = 1'b0; acc_write = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic check_image(input string req);
    logic [127:0] m;
    for (int i = 0; i < 16; i++) m[i*8 +: 8] = m_reg[i];
    check(reg_image == m, req, "reg_image", reg_image, m);
  endtask

  // Monitor: pops and compares each response in its cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (sb.size() == 0) check(1'b0, "R11", "unexpected rsp_valid", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          popped++;
          check(rsp_rdata == e.rdata, $sformatf("R4/R5 rq%0d", e.rq), "rsp_rdata", rsp_rdata, e.rdata);
          check(rsp_wait == e.wt, $sformatf("R10 rq%0d", e.rq), "rsp_wait", rsp_wait, e.wt);
          check({env_pos_clr, env_restart, amp_upd} == e.stb,
                $sformatf("R7/R8/R9 rq%0d", e.rq), "strobes",
                {env_pos_clr, env_restart, amp_upd}, e.stb);
        end
      end else if ({env_pos_clr, env_restart, amp_upd} != 5'b0) begin
        check(1'b0, "R7/R8/R9", "strobe outside response", {env_pos_clr, env_restart, amp_upd}, 0);
      end
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rsp_valid == 1'b0 && rsp_wait == 3'd0 && rsp_rdata == 8'hFF, "R1", "rsp after reset",
          {rsp_valid, rsp_wait, rsp_rdata}, {1'b0, 3'd0, 8'hFF});
    check_image("R1");
    acc(0, 8'h00, 8'h00, 1);       // R1 R4: reg0 reads 0
    // R2 R3 R9: amplitude registers with channel strobes
    acc(1, 8'h00, 8'h08, 2); acc(1, 8'h02, 8'h1F, 2);
    acc(1, 8'h00, 8'h09, 3); acc(1, 8'h02, 8'h0A, 3);
    acc(1, 8'h00, 8'h0A, 4); acc(1, 8'h02, 8'h05, 4);
    // R7 R8: envelope registers
    acc(1, 8'h00, 8'h0C, 5); acc(1, 8'h02, 8'h33, 5);
    acc(1, 8'h00, 8'h0D, 6); acc(1, 8'h02, 8'h0E, 6);
    acc(1, 8'h00, 8'h00, 7); acc(1, 8'h02, 8'h55, 7);
    idle(2);
    check_image("R3");
    // R4: read back through select
    acc(1, 8'h00, 8'h09, 8); acc(0, 8'h00, 8'h00, 8);
    acc(1, 8'h00, 8'h0C, 8); acc(0, 8'h00, 8'h00, 8);
    acc(1, 8'h00, 8'h0F, 8); acc(0, 8'h00, 8'h00, 8);
    // R3 R4: select out of range ignored, reads 0xFF
    acc(1, 8'h00, 8'h10, 9); acc(1, 8'h02, 8'hAA, 9); acc(0, 8'h00, 8'h00, 9);
    acc(1, 8'h00, 8'hFF, 9); acc(1, 8'h02, 8'hBB, 9); acc(0, 8'h00, 8'h00, 9);
    idle(2);
    check_image("R3");
    // R5: open lanes
    acc(1, 8'h00, 8'h08, 10);
    acc(0, 8'h01, 8'h00, 10); acc(0, 8'h02, 8'h00, 10); acc(0, 8'h03, 8'h00, 10);
    // R6: odd-lane writes ignored; sel stays 8
    acc(1, 8'h01, 8'h05, 11); acc(1, 8'h03, 8'h77, 11); acc(0, 8'h00, 8'h00, 11);
    idle(2);
    check_image("R6");
    // R10: mirrored window above the low four bytes
    acc(1, 8'h44, 8'h0B, 12); acc(1, 8'h46, 8'hC3, 12); acc(0, 8'h40, 8'h00, 12);
    acc(0, 8'h45, 8'h00, 12); acc(1, 8'h47, 8'h11, 12);
    idle(3);
    check_image("R10");
    // R11: every access answered exactly once
    check(pushed == popped && sb.size() == 0, "R11", "responses", popped, pushed);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule